// File: doc/BRIEF.md
# LCD controller register interface

This block is the software-visible register file of a colour LCD controller. It sits on a simple 32-bit bus that uses byte addresses within a 4 KB window and transfers whole words. It holds four timing words, the base addresses of the upper and lower panels, a control word, an interrupt mask and a raw interrupt status. From these values it continuously derives the display geometry (active columns and rows), the pixel-depth code, three ordering flags and a display-enable flag. The pixel fetch engine and the scan timing logic use these outputs.

A two-bit variant input selects the flavour of the controller. Any variant other than the base one exchanges the addresses of the control and interrupt-mask words. Variant 2 also reports a different identification sequence. Accesses that fall in the palette window are passed through to an external palette port, and the palette storage lives outside this block. Interrupt events are not generated here. Status bits enter only through a set input, and software clears them through a write-one-to-clear word.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored register reads zero, `rd_valid` is low, `disp_en` and all ordering flags are low, and the derived geometry is therefore 16 columns by 1 row.
- R2: Word offsets 0 to 3 (byte 0x00 to 0x0C) hold timing words 0 to 3. Word 4 (0x10) holds the upper base and word 5 (0x14) holds the lower base, and all six read back as written. Words 11 (0x2C) and 12 (0x30) read back the upper and lower base and ignore writes.
- R3: With `variant` = 0, word 6 (0x18) is the interrupt mask and word 7 (0x1C) is the control word. With any other variant the two addresses are exchanged for both reads and writes. The mask stores the low `SW` bits of the written data and reads back zero-extended.
- R4: Word 8 (0x20) reads the raw status and word 9 (0x24) reads the raw status ANDed with the mask. Both ignore writes. Every bit set in `stat_set` during a cycle is set in the raw status at the end of that cycle.
- R5: A write to word 10 (0x28) clears every raw status bit that is 1 in the low `SW` bits of the write data. If a bit is set by `stat_set` and cleared in the same cycle, the set wins. Word 10 reads zero.
- R6: `disp_en` is 1 exactly when control bit 0 and control bit 11 are both 1.
- R7: `act_cols` equals ((timing0 & 0xFC) + 4) * 4, giving a range of 16 to 1024, and `act_rows` equals (timing1 & 0x3FF) + 1.
- R8: `pix_depth` is control bits [3:1]. `rgb_swap` is control bit 8, `byte_be` is control bit 9 and `pix_be` is control bit 10.
- R9: Byte addresses 0xFE0 to 0xFFF read one identification byte, zero-extended, from the position given by address bits [4:2]. For variants 0, 1 and 3 the sequence is 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. For variant 2 it is the same except that position 0 is 0x11 and position 2 is 0x24.
- R10: For byte addresses 0x200 to 0x3FF, `pal_sel` is 1 and `pal_index` is address bits [8:2]. On a write, `pal_we` is 1 and `pal_wdata` equals the bus write data. A read returns `pal_rdata`. No register changes on a palette access.
- R11: Reads of any other address return zero, and writes to them change no register.
- R12: A read issued in one cycle presents `rd_data` together with `rd_valid` = 1 after the next rising clock edge. A register write takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant | input | 2 | Controller flavour: 0 base, 1 swapped, 2 swapped with alternate ID |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address in the window, word aligned |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| stat_set | input | SW | Sets raw status bits |
| pal_sel | output | 1 | Access falls in palette window |
| pal_we | output | 1 | Palette write strobe |
| pal_index | output | 7 | Palette word index |
| pal_wdata | output | DW | Palette write data |
| pal_rdata | input | DW | Palette read data |
| act_cols | output | 11 | Active pixels per line |
| act_rows | output | 11 | Active lines per frame |
| pix_depth | output | 3 | Bits-per-pixel code |
| rgb_swap | output | 1 | BGR component order |
| byte_be | output | 1 | Big-endian byte order |
| pix_be | output | 1 | Big-endian pixel order |
| disp_en | output | 1 | Enabled and powered |

## Verification
The hardest case to reach from the ports is a clear of a status bit that arrives in the same cycle as a new set event for that bit, combined with a mask view taken through the swapped address map. The bench drives `stat_set` and the clear word in the same cycle, and it reads the masked status under each variant after writing the mask through the address that variant assigns. The random phase mixes writes to read-only, unmapped, palette and identification addresses with reads of every mapped word, so that any stray side effect appears in a later readback.

// File: rtl/lcdc_regs.sv
module lcdc_regs #(
  parameter int DW = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    variant,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [11:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [SW-1:0] stat_set,
  output logic          pal_sel,
  output logic          pal_we,
  output logic [6:0]    pal_index,
  output logic [DW-1:0] pal_wdata,
  input  logic [DW-1:0] pal_rdata,
  output logic [10:0]   act_cols,
  output logic [10:0]   act_rows,
  output logic [2:0]    pix_depth,
  output logic          rgb_swap,
  output logic          byte_be,
  output logic          pix_be,
  output logic          disp_en
);

  localparam logic [9:0] W_UPB  = 10'd4;
  localparam logic [9:0] W_LPB  = 10'd5;
  localparam logic [9:0] W_RAW  = 10'd8;
  localparam logic [9:0] W_MSK  = 10'd9;
  localparam logic [9:0] W_CLR  = 10'd10;
  localparam logic [9:0] W_UPC  = 10'd11;
  localparam logic [9:0] W_LPC  = 10'd12;

  logic [DW-1:0] tim [4];
  logic [DW-1:0] up_base, lo_base, ctrl;
  logic [SW-1:0] imask, raw;
  logic [DW-1:0] rdata_c;

  wire        wr      = req_valid &  req_write;
  wire        rd      = req_valid & ~req_write;
  wire [9:0]  widx    = req_addr[11:2];
  wire        in_pal  = (req_addr[11:9] == 3'b001);
  wire        in_id   = (req_addr[11:5] == 7'h7F);
  wire        swapped = (variant != 2'd0);
  wire [9:0]  w_ctrl  = swapped ? 10'd6 : 10'd7;
  wire [9:0]  w_mask  = swapped ? 10'd7 : 10'd6;
  wire        hit_clr = wr && (widx == W_CLR);
  wire [SW-1:0] clr_bits = hit_clr ? req_wdata[SW-1:0] : '0;

  function automatic logic [7:0] id_byte(input logic [2:0] pos, input logic alt);
    case (pos)
      3'd0: id_byte = alt ? 8'h11 : 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = alt ? 8'h24 : 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim[i] <= '0;
      up_base <= '0;
      lo_base <= '0;
      ctrl    <= '0;
      imask   <= '0;
    end else if (wr) begin
      if (widx < 10'd4) tim[widx[1:0]] <= req_wdata;
      if (widx == W_UPB) up_base <= req_wdata;
      if (widx == W_LPB) lo_base <= req_wdata;
      if (widx == w_ctrl) ctrl <= req_wdata;
      if (widx == w_mask) imask <= req_wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_bits) | stat_set;
  end

  always_comb begin
    rdata_c = '0;
    if (in_id) begin
      rdata_c[7:0] = id_byte(req_addr[4:2], variant == 2'd2);
    end else if (in_pal) begin
      rdata_c = pal_rdata;
    end else if (widx < 10'd4) begin
      rdata_c = tim[widx[1:0]];
    end else if (widx == W_UPB || widx == W_UPC) begin
      rdata_c = up_base;
    end else if (widx == W_LPB || widx == W_LPC) begin
      rdata_c = lo_base;
    end else if (widx == w_ctrl) begin
      rdata_c = ctrl;
    end else if (widx == w_mask) begin
      rdata_c[SW-1:0] = imask;
    end else if (widx == W_RAW) begin
      rdata_c[SW-1:0] = raw;
    end else if (widx == W_MSK) begin
      rdata_c[SW-1:0] = raw & imask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rdata_c : '0;
    end
  end

  assign pal_sel   = req_valid & in_pal;
  assign pal_we    = wr & in_pal;
  assign pal_index = req_addr[8:2];
  assign pal_wdata = req_wdata;

  assign act_cols  = {({1'b0, tim[0][7:2]} + 7'd1), 4'b0000};
  assign act_rows  = {1'b0, tim[1][9:0]} + 11'd1;
  assign pix_depth = ctrl[3:1];
  assign rgb_swap  = ctrl[8];
  assign byte_be   = ctrl[9];
  assign pix_be    = ctrl[10];
  assign disp_en   = ctrl[0] & ctrl[11];

  wire unmapped = !in_id && !in_pal && (widx > W_LPC);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid); // R12

  AST_ENABLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == w_ctrl && req_wdata[0] && req_wdata[11]) |=> disp_en); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr && req_wdata[0] && !stat_set[0]) |=> !raw[0]); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && unmapped) |=> (rd_data == '0)); // R11

  AST_PAL_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_pal) |=> ($stable(ctrl) && $stable(imask) && $stable(up_base))); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set[0] |=> raw[0]); // R4

endmodule

// File: tb/lcdc_regs_bench.sv
module lcdc_regs_bench;
  localparam int DW = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    variant = 2'd0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] stat_set = '0;
  logic          pal_sel, pal_we;
  logic [6:0]    pal_index;
  logic [DW-1:0] pal_wdata, pal_rdata;
  logic [10:0]   act_cols, act_rows;
  logic [2:0]    pix_depth;
  logic          rgb_swap, byte_be, pix_be, disp_en;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] m_tim [4];
  logic [DW-1:0] m_up, m_lo, m_ctrl;
  logic [SW-1:0] m_mask, m_raw;

  always #2.5 clk = ~clk;

  assign pal_rdata = {16'hC0DE, 9'b0, pal_index};

  lcdc_regs #(.DW(DW), .SW(SW)) u_lcdc_regs (
    .clk(clk), .rst_n(rst_n), .variant(variant),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .stat_set(stat_set), .pal_sel(pal_sel), .pal_we(pal_we),
    .pal_index(pal_index), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
    .act_cols(act_cols), .act_rows(act_rows), .pix_depth(pix_depth),
    .rgb_swap(rgb_swap), .byte_be(byte_be), .pix_be(pix_be), .disp_en(disp_en)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(input int pos, input logic [1:0] v);
    logic [7:0] seq [8];
    seq = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 2'd2) begin seq[0] = 8'h11; seq[2] = 8'h24; end
    return seq[pos];
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [11:0] a);
    int w = a >> 2;
    int cw = (variant == 0) ? 7 : 6;
    int mw = (variant == 0) ? 6 : 7;
    if (a >= 12'hFE0) return {24'b0, exp_id((a - 12'hFE0) >> 2, variant)};
    if (a >= 12'h200 && a < 12'h400) return {16'hC0DE, 9'b0, a[8:2]};
    if (w < 4) return m_tim[w];
    if (w == 4 || w == 11) return m_up;
    if (w == 5 || w == 12) return m_lo;
    if (w == cw) return m_ctrl;
    if (w == mw) return {{(DW-SW){1'b0}}, m_mask};
    if (w == 8) return {{(DW-SW){1'b0}}, m_raw};
    if (w == 9) return {{(DW-SW){1'b0}}, m_raw & m_mask};
    return '0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [DW-1:0] d);
    int w = a >> 2;
    int cw = (variant == 0) ? 7 : 6;
    int mw = (variant == 0) ? 6 : 7;
    if (a >= 12'h200) return;
    if (w < 4) m_tim[w] = d;
    else if (w == 4) m_up = d;
    else if (w == 5) m_lo = d;
    else if (w == cw) m_ctrl = d;
    else if (w == mw) m_mask = d[SW-1:0];
  endtask

  task automatic check_derived();
    chk("R7 cols", {21'b0, act_cols}, ((m_tim[0] & 32'hFC) + 4) * 4);
    chk("R7 rows", {21'b0, act_rows}, (m_tim[1] & 32'h3FF) + 1);
    chk("R6 disp_en", {31'b0, disp_en}, {31'b0, m_ctrl[0] & m_ctrl[11]});
    chk("R8 flags", {26'b0, pix_depth, rgb_swap, byte_be, pix_be},
        {26'b0, m_ctrl[3:1], m_ctrl[8], m_ctrl[9], m_ctrl[10]});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [DW-1:0] d,
                          input logic [SW-1:0] set = '0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; stat_set = set;
    #1;
    if (a >= 12'h200 && a < 12'h400) begin
      chk("R10 pal strobe", {30'b0, pal_sel, pal_we}, 32'd3);
      chk("R10 pal index", {25'b0, pal_index}, {25'b0, a[8:2]});
      chk("R10 pal wdata", pal_wdata, d);
    end
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; stat_set = '0;
    model_write(a, d);
    if ((a >> 2) == 10) m_raw = m_raw & ~d[SW-1:0];
    m_raw = m_raw | set;
    check_derived();
  endtask

  task automatic do_read(input logic [11:0] a, input string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    e = exp_read(a);
    @(posedge clk); #1;
    req_valid = 0;
    chk({tag, " R12 valid"}, {31'b0, rd_valid}, 32'd1);
    chk(tag, rd_data, e);
  endtask

  task automatic pulse_set(input logic [SW-1:0] v);
    @(negedge clk); stat_set = v;
    @(posedge clk); #1; stat_set = '0;
    m_raw = m_raw | v;
  endtask

  function automatic logic [11:0] rand_addr();
    int r = $urandom % 20;
    if (r <= 12) return 12'(r * 4);
    if (r == 13) return 12'h028;
    if (r <= 15) return 12'h200 + 12'(($urandom % 128) * 4);
    if (r == 16) return 12'hFE0 + 12'(($urandom % 8) * 4);
    if (r == 17) return 12'(13 * 4 + ($urandom % 115) * 4);
    return 12'h400 + 12'(($urandom % 12'h2F8) * 4);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    m_up = '0; m_lo = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    check_derived();
    chk("R1 cols16", {21'b0, act_cols}, 32'd16);
    chk("R1 rows1", {21'b0, act_rows}, 32'd1);
    for (int w = 0; w < 13; w++) do_read(12'(w * 4), "R1 reset read");

    do_write(12'h000, 32'h0000_00FC);
    chk("R7 cols max", {21'b0, act_cols}, 32'd1024);
    do_write(12'h004, 32'hFFFF_FFFF);
    chk("R7 rows max", {21'b0, act_rows}, 32'd1024);
    do_write(12'h010, 32'h1234_5678);
    do_write(12'h014, 32'h9ABC_DEF0);
    do_read(12'h02C, "R2 upper current");
    do_read(12'h030, "R2 lower current");
    do_write(12'h02C, 32'hDEAD_BEEF);
    do_read(12'h010, "R2 current ignores write");

    do_write(12'h01C, 32'h0000_0001);
    chk("R6 enable without power", {31'b0, disp_en}, 32'd0);
    do_write(12'h01C, 32'h0000_0801);
    chk("R6 enable with power", {31'b0, disp_en}, 32'd1);
    do_write(12'h018, 32'h0000_0015);
    do_read(12'h018, "R3 mask base");

    variant = 2'd1;
    do_read(12'h018, "R3 ctrl swapped");
    do_read(12'h01C, "R3 mask swapped");
    do_write(12'h01C, 32'hFFFF_FFEA);
    do_read(12'h01C, "R3 mask trunc");
    variant = 2'd0;

    pulse_set(5'b10011);
    do_read(12'h020, "R4 raw");
    do_read(12'h024, "R4 masked");
    do_write(12'h020, 32'hFFFF_FFFF);
    do_read(12'h020, "R4 raw ignores write");
    do_write(12'h028, 32'h0000_0001, 5'b00001);
    do_read(12'h020, "R5 set wins");
    do_write(12'h028, 32'h0000_0003);
    do_read(12'h020, "R5 clear");
    do_read(12'h028, "R5 clear reads zero");

    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      for (int p = 0; p < 8; p++) do_read(12'hFE0 + 12'(p * 4), "R9 id");
    end
    variant = 2'd0;

    do_write(12'h3FC, 32'h5555_AAAA);
    do_read(12'h200, "R10 pal read");
    do_read(12'h01C, "R10 no side effect");
    do_write(12'h040, 32'hFFFF_FFFF);
    do_write(12'h800, 32'hFFFF_FFFF);
    do_read(12'h040, "R11 unmapped");
    do_read(12'h1FC, "R11 unmapped top");

    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 10;
      if (n % 150 == 0) variant = 2'($urandom % 4);
      if (op < 4) do_write(rand_addr(), $urandom);
      else if (op == 4) pulse_set(SW'($urandom));
      else if (op == 5) do_write(12'h028, $urandom, SW'($urandom));
      else do_read(rand_addr(), "R2 R3 R4 R11 random read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule